// File: doc/BRIEF.md
# Banked index address generator

This block produces the 20-bit physical operand address for a small 8-bit processor. The processor has two 16-bit index registers, X and Y, and each one is paired with a 4-bit bank register held inside this block. For index-based modes, the offset is formed within a 16-bit space. The bank of the index register in use then supplies the top four address bits. Every other mode is confined to the lowest 64 KiB, because the bank field is forced to zero.

The address path is purely combinational. The decoder presents a mode code, both index values, an 8-bit displacement and a 16-bit direct address, and the physical address appears in the same cycle. The bank registers are the only state. Each one is written through its own synchronous load enable from a shared 4-bit data port.

One write pattern is undefined: a register-indirect X write while X holds FFECh. The block flags this pattern and holds back the write strobe it forwards to the bus.

Top module: `bidx_addr_gen`

## Requirements
- R1: In mode 3 (X plus displacement) and mode 4 (Y plus displacement), `addr_o[15:0]` equals the index value plus the displacement, modulo 2^16.
- R2: A carry or borrow out of bit 15 of that sum is discarded and never changes `addr_o[19:16]`. With Y bank 6, Y = FFF0h and displacement 23h, the result is 60013h.
- R3: In modes 1 and 3, `addr_o[19:16]` is the X bank register. In modes 2 and 4, it is the Y bank register.
- R4: In mode 1 (X indirect) and mode 2 (Y indirect), the displacement is ignored and `addr_o[15:0]` equals the index value.
- R5: In mode 0 (direct) and in the unused codes 5, 6 and 7, `addr_o` equals `{4'h0, dir_addr_i}`.
- R6: The displacement is two's complement. Values 80h to FFh count as -128 to -1.
- R7: Both bank registers reset to 0. A bank register loads `bank_data_i` at a rising clock edge while its load enable is high. The new value shows in `addr_o` from that edge onward and not before it.
- R8: When `wr_req_i` is high, the mode is 1 and `ix_i` is FFECh, `undef_o` is 1 and `wr_strobe_o` is 0. In every other case, `undef_o` is 0 and `wr_strobe_o` equals `wr_req_i`.
- R9: `addr_o`, `undef_o` and `wr_strobe_o` depend combinationally on the inputs in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the bank registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_xbank_i | input | 1 | Load enable for the X bank register |
| ld_ybank_i | input | 1 | Load enable for the Y bank register |
| bank_data_i | input | 4 | Value to load into a bank register |
| mode_i | input | 3 | Addressing mode code (0 direct, 1 X indirect, 2 Y indirect, 3 X+d, 4 Y+d) |
| ix_i | input | 16 | X index register value |
| iy_i | input | 16 | Y index register value |
| disp_i | input | 8 | Signed displacement |
| dir_addr_i | input | 16 | Direct or non-indexed operand address |
| wr_req_i | input | 1 | Current access is a write |
| addr_o | output | 20 | Physical operand address |
| undef_o | output | 1 | Access is undefined |
| wr_strobe_o | output | 1 | Write strobe forwarded to the bus |

## Verification
The assertions assume that every input is at a known level at each rising clock edge. They also assume that the mode code does not change in the same cycle that a bank load is checked, so that the address seen after a load belongs to the same index family. The stimulus changes inputs only at falling edges and keeps the mode steady across every bank-load cycle. Unused mode codes and both load enables high together are legal, and the stimulus drives both cases.

// File: rtl/bidx_pkg.sv
package bidx_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_DIRECT = 3'd0,
    AM_IND_X  = 3'd1,
    AM_IND_Y  = 3'd2,
    AM_DISP_X = 3'd3,
    AM_DISP_Y = 3'd4
  } am_e;

  typedef struct packed {
    logic use_idx;
    logic sel_y;
    logic add_disp;
  } am_ctl_t;
endpackage

// File: rtl/bidx_mode_dec.sv
module bidx_mode_dec
  import bidx_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output am_ctl_t           ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (mode_i)
      AM_IND_X:  ctl_o = '{use_idx: 1'b1, sel_y: 1'b0, add_disp: 1'b0};
      AM_IND_Y:  ctl_o = '{use_idx: 1'b1, sel_y: 1'b1, add_disp: 1'b0};
      AM_DISP_X: ctl_o = '{use_idx: 1'b1, sel_y: 1'b0, add_disp: 1'b1};
      AM_DISP_Y: ctl_o = '{use_idx: 1'b1, sel_y: 1'b1, add_disp: 1'b1};
      default:   ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/bidx_bank_regs.sv
module bidx_bank_regs #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_BANKS-1:0]             ld_i,
  input  logic [BANK_W-1:0]                data_i,
  output logic [NUM_BANKS-1:0][BANK_W-1:0] bank_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bank_o[g] <= '0;
      else if (ld_i[g])  bank_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/bidx_offset_add.sv
module bidx_offset_add #(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [OFS_W-1:0]  base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              en_i,
  output logic [OFS_W-1:0]  sum_o
);
  localparam int unsigned EXT_W = OFS_W - DISP_W;

  logic [OFS_W-1:0] disp_ext;

  always_comb begin
    disp_ext = en_i ? {{EXT_W{disp_i[DISP_W-1]}}, disp_i} : '0;
    sum_o    = base_i + disp_ext; // carry out dropped by width
  end
endmodule

// File: rtl/bidx_addr_gen.sv
module bidx_addr_gen
  import bidx_pkg::*;
#(
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned DISP_W     = 8,
  parameter logic [15:0] HAZARD_PTR = 16'hFFEC
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_xbank_i,
  input  logic                    ld_ybank_i,
  input  logic [BANK_W-1:0]       bank_data_i,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic [OFS_W-1:0]        ix_i,
  input  logic [OFS_W-1:0]        iy_i,
  input  logic [DISP_W-1:0]       disp_i,
  input  logic [OFS_W-1:0]        dir_addr_i,
  input  logic                    wr_req_i,
  output logic [OFS_W+BANK_W-1:0] addr_o,
  output logic                    undef_o,
  output logic                    wr_strobe_o
);
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BX = 0;
  localparam int unsigned BY = 1;

  am_ctl_t                         ctl;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q;
  logic [OFS_W-1:0]                idx_sel;
  logic [OFS_W-1:0]                ofs;
  logic [BANK_W-1:0]               bank_sel;

  bidx_mode_dec u_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  bidx_bank_regs #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_banks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   ({ld_ybank_i, ld_xbank_i}),
    .data_i (bank_data_i),
    .bank_o (bank_q)
  );

  assign idx_sel = ctl.sel_y ? iy_i : ix_i;

  bidx_offset_add #(
    .OFS_W  (OFS_W),
    .DISP_W (DISP_W)
  ) u_add (
    .base_i (idx_sel),
    .disp_i (disp_i),
    .en_i   (ctl.add_disp),
    .sum_o  (ofs)
  );

  assign bank_sel = ctl.sel_y ? bank_q[BY] : bank_q[BX];

  always_comb begin
    if (ctl.use_idx) addr_o = {bank_sel, ofs};
    else             addr_o = {{BANK_W{1'b0}}, dir_addr_i};
  end

  // undefined write through X indirect at the hazard pointer
  assign undef_o     = wr_req_i && (mode_i == AM_IND_X) && (ix_i == HAZARD_PTR[OFS_W-1:0]);
  assign wr_strobe_o = wr_req_i && !undef_o;
endmodule

// File: rtl/bidx_addr_gen_chk.sv
module bidx_addr_gen_chk
  import bidx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_xbank_i,
  input logic              ld_ybank_i,
  input logic [3:0]        bank_data_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [15:0]       ix_i,
  input logic              wr_req_i,
  input logic [19:0]       addr_o,
  input logic              undef_o,
  input logic              wr_strobe_o
);
  logic non_idx;
  logic x_fam;
  logic y_fam;

  assign non_idx = (mode_i == AM_DIRECT) || (mode_i > AM_DISP_Y);
  assign x_fam   = (mode_i == AM_IND_X) || (mode_i == AM_DISP_X);
  assign y_fam   = (mode_i == AM_IND_Y) || (mode_i == AM_DISP_Y);

  assert_bank_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    non_idx |-> (addr_o[19:16] == 4'h0));

  assert_ind_x_no_disp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == AM_IND_X) |-> (addr_o[15:0] == ix_i));

  assert_no_strobe_when_undef_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !wr_strobe_o);

  assert_strobe_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> wr_req_i);

  assert_xbank_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_xbank_i && x_fam) |=> (!x_fam || (addr_o[19:16] == $past(bank_data_i))));

  assert_ybank_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ybank_i && y_fam) |=> (!y_fam || (addr_o[19:16] == $past(bank_data_i))));
endmodule

bind bidx_addr_gen bidx_addr_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_xbank_i  (ld_xbank_i),
  .ld_ybank_i  (ld_ybank_i),
  .bank_data_i (bank_data_i),
  .mode_i      (mode_i),
  .ix_i        (ix_i),
  .wr_req_i    (wr_req_i),
  .addr_o      (addr_o),
  .undef_o     (undef_o),
  .wr_strobe_o (wr_strobe_o)
);

// File: tb/bidx_addr_gen_tb.sv
`timescale 1ns/1ps
module bidx_addr_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_xbank_i = 1'b0;
  logic        ld_ybank_i = 1'b0;
  logic [3:0]  bank_data_i = '0;
  logic [2:0]  mode_i = '0;
  logic [15:0] ix_i = '0;
  logic [15:0] iy_i = '0;
  logic [7:0]  disp_i = '0;
  logic [15:0] dir_addr_i = '0;
  logic        wr_req_i = 1'b0;
  logic [19:0] addr_o;
  logic        undef_o;
  logic        wr_strobe_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bidx_addr_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_xbank_i(ld_xbank_i), .ld_ybank_i(ld_ybank_i),
    .bank_data_i(bank_data_i), .mode_i(mode_i), .ix_i(ix_i), .iy_i(iy_i), .disp_i(disp_i),
    .dir_addr_i(dir_addr_i), .wr_req_i(wr_req_i), .addr_o(addr_o), .undef_o(undef_o),
    .wr_strobe_o(wr_strobe_o)
  );

  task automatic apply(input logic [2:0] m, input logic [15:0] x, input logic [15:0] y,
                       input logic [7:0] d, input logic [15:0] da, input logic w);
    mode_i = m; ix_i = x; iy_i = y; disp_i = d; dir_addr_i = da; wr_req_i = w;
    #1;
  endtask

  task automatic chk(input string req, input logic [19:0] ea, input logic eu, input logic es);
    n_vec++;
    if (addr_o !== ea || undef_o !== eu || wr_strobe_o !== es) begin
      n_bad++;
      $display("FAIL %s: addr=%05h undef=%b strobe=%b expected addr=%05h undef=%b strobe=%b",
               req, addr_o, undef_o, wr_strobe_o, ea, eu, es);
    end
  endtask

  // R7: load at falling edge, visible only after the next rising edge
  task automatic load_banks(input logic lx, input logic ly, input logic [3:0] v);
    @(negedge clk_i);
    ld_xbank_i = lx; ld_ybank_i = ly; bank_data_i = v;
    @(negedge clk_i);
    ld_xbank_i = 1'b0; ld_ybank_i = 1'b0;
  endtask

  task automatic t_reset();
    apply(3'd3, 16'h1234, 16'h0, 8'h00, 16'h0, 1'b0);
    chk("R7 reset X bank", 20'h01234, 1'b0, 1'b0);
    apply(3'd4, 16'h0, 16'h5678, 8'h00, 16'h0, 1'b0);
    chk("R7 reset Y bank", 20'h05678, 1'b0, 1'b0);
  endtask

  task automatic t_load_timing();
    @(negedge clk_i);
    apply(3'd1, 16'h2222, 16'h0, 8'h00, 16'h0, 1'b0);
    ld_xbank_i = 1'b1; bank_data_i = 4'h3;
    #1;
    chk("R7 before edge", 20'h02222, 1'b0, 1'b0);
    @(negedge clk_i);
    ld_xbank_i = 1'b0;
    #1;
    chk("R7 after edge", 20'h32222, 1'b0, 1'b0);
    load_banks(1'b0, 1'b1, 4'h6);
    apply(3'd2, 16'h0, 16'h1111, 8'h00, 16'h0, 1'b0);
    chk("R7 Y load", 20'h61111, 1'b0, 1'b0);
    apply(3'd1, 16'h2222, 16'h0, 8'h00, 16'h0, 1'b0);
    chk("R7 X untouched by Y load", 20'h32222, 1'b0, 1'b0);
  endtask

  task automatic t_disp_wrap();
    apply(3'd4, 16'h0, 16'hFFF0, 8'h23, 16'h0, 1'b0);
    chk("R2 Y carry dropped", 20'h60013, 1'b0, 1'b0);
    apply(3'd3, 16'hFFFF, 16'h0, 8'h01, 16'h0, 1'b0);
    chk("R2 X carry dropped", 20'h30000, 1'b0, 1'b0);
    apply(3'd3, 16'h0005, 16'h0, 8'hF0, 16'h0, 1'b0);
    chk("R6 borrow below zero", 20'h3FFF5, 1'b0, 1'b0);
    apply(3'd3, 16'h1000, 16'h0, 8'h80, 16'h0, 1'b0);
    chk("R6 most negative", 20'h30F80, 1'b0, 1'b0);
    apply(3'd4, 16'h0, 16'h1000, 8'h7F, 16'h0, 1'b0);
    chk("R1 positive add", 20'h6107F, 1'b0, 1'b0);
    apply(3'd4, 16'h0, 16'h0000, 8'hFF, 16'h0, 1'b0);
    chk("R6 minus one wrap", 20'h6FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_indirect();
    apply(3'd1, 16'h4321, 16'h8765, 8'h55, 16'hAAAA, 1'b0);
    chk("R4 X indirect", 20'h34321, 1'b0, 1'b0);
    apply(3'd2, 16'h4321, 16'h8765, 8'hAA, 16'hAAAA, 1'b0);
    chk("R4 Y indirect", 20'h68765, 1'b0, 1'b0);
  endtask

  task automatic t_bank_select();
    load_banks(1'b1, 1'b1, 4'hA);
    load_banks(1'b0, 1'b1, 4'h5);
    apply(3'd3, 16'h0100, 16'h0200, 8'h01, 16'h0, 1'b0);
    chk("R3 X bank pick", 20'hA0101, 1'b0, 1'b0);
    apply(3'd4, 16'h0100, 16'h0200, 8'h01, 16'h0, 1'b0);
    chk("R3 Y bank pick", 20'h50201, 1'b0, 1'b0);
  endtask

  task automatic t_non_indexed();
    for (int m = 0; m < 8; m++) begin
      if (m >= 1 && m <= 4) continue;
      apply(3'(m), 16'hFFFF, 16'hFFFF, 8'h7F, 16'hABCD, 1'b1);
      chk("R5 bank forced zero", 20'h0ABCD, 1'b0, 1'b1);
    end
  endtask

  task automatic t_hazard();
    apply(3'd1, 16'hFFEC, 16'h0, 8'h00, 16'h0, 1'b1);
    chk("R8 undefined write", 20'hAFFEC, 1'b1, 1'b0);
    apply(3'd1, 16'hFFEC, 16'h0, 8'h00, 16'h0, 1'b0);
    chk("R8 read not flagged", 20'hAFFEC, 1'b0, 1'b0);
    apply(3'd3, 16'hFFEC, 16'h0, 8'h00, 16'h0, 1'b1);
    chk("R8 X+d not flagged", 20'hAFFEC, 1'b0, 1'b1);
    apply(3'd2, 16'h0, 16'hFFEC, 8'h00, 16'h0, 1'b1);
    chk("R8 Y indirect not flagged", 20'h5FFEC, 1'b0, 1'b1);
    apply(3'd1, 16'hFFED, 16'h0, 8'h00, 16'h0, 1'b1);
    chk("R8 other pointer R9", 20'hAFFED, 1'b0, 1'b1);
  endtask

  initial begin
    #1;
    t_reset();
    #20;
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_load_timing();
    t_disp_wrap();
    t_indirect();
    t_bank_select();
    t_non_indexed();
    t_hazard();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule